// File: doc/BRIEF.md
# Cluster-Sampled Label Alignment Unit

This unit sits beside a parallel neural-network equalizer whose weights are refined while live traffic flows. Every group of pre-activation outputs the equalizer produces is counted into clusters of a fixed length. Only the first group of each cluster is kept, in a single one-group holding register, while its decisions travel through a slow error-correcting decoder. When the corrected decisions come back as labels, the unit pairs them with the held outputs. It then emits one signed error value per output neuron for a separate weight-update engine.

Each 2-bit label symbol is turned into an 8-bit target level. The error is the held output minus that target. A lane is forced to zero when its held output lies outside the clipping range of the activation, because the derivative there is zero. Labels that the decoder flags as uncorrectable produce no error vector, and a counter records them. Feedback is made of labels only, so the equalizer's data path stays free of loops. The cluster length should be at least the decoder latency plus one, so that a returning label frees the holder in the same cycle as the next cluster start. If a label is late, that cluster's sample is skipped and the held sample is kept.

Top module: `lbl_align_unit`

## Requirements
- R1: A position counter advances once for each cycle with `grp_valid`=1 and wraps after CLUSTER_LEN groups. Position 0, which is the first valid group after reset, is a cluster start. Cycles with `grp_valid`=0 do not move it.
- R2: A valid group at position 0 is captured when the holder is empty. Groups at any other position are never captured.
- R3: A cluster start that arrives while a sample is pending, with no label in the same cycle, is skipped. The held sample stays unchanged.
- R4: A label with `lbl_valid`=1 and `lbl_bad`=0 that arrives while a sample is pending sets `err_valid` for exactly the next cycle, with `err_vec` computed from the held sample. It also frees the holder.
- R5: A label with `lbl_bad`=1 that arrives while a sample is pending frees the holder and produces no `err_valid`. In that case `drop_count` increases by one in the next cycle.
- R6: The label symbol for lane k is `lbl_sym[2k+1:2k]`. Its target level is 85 times the symbol value, which gives 0, 85, 170 or 255.
- R7: The error for lane k is `err_vec[9k+8:9k]`, a two's-complement 9-bit value equal to the held raw value of lane k (a signed ACC_W-bit field `grp_raw[ACC_W*k +: ACC_W]`) minus its target. The lane is 0 when that raw value is below 0 or above 255.
- R8: A label that arrives while no sample is pending is ignored: `err_valid` stays 0 and `drop_count` is unchanged.
- R9: While `rst`=1 (synchronous, active high), `err_valid` and `drop_count` go to 0, the holder empties and the position returns to 0.
- R10: When a label and the next cluster start arrive in the same cycle, the error comes from the old sample and the new group is captured in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grp_valid | input | 1 | An output group is present this cycle |
| grp_raw | input | NEURONS*ACC_W | Signed pre-activation values, one field per lane |
| lbl_valid | input | 1 | A corrected label arrives this cycle |
| lbl_bad | input | 1 | The arriving label is uncorrectable |
| lbl_sym | input | NEURONS*2 | Corrected 2-bit symbols, one per lane |
| err_valid | output | 1 | One-cycle strobe for a new error vector |
| err_vec | output | NEURONS*9 | Signed per-lane errors |
| drop_count | output | CNT_W | Number of dropped uncorrectable labels |

## Verification
A table of held samples is sent through the capture-and-label cycle. The table mixes lanes that exactly hit each target level, lanes with large positive and negative errors, and lanes pushed just past both clipping bounds and to the extremes of the signed range. These cases separate a correct subtract-and-gate from a wrong level map, a wrong sign or an off-by-one range test. Directed sequences then exercise the following:
- a cluster start that lands while a sample is still pending, which shows whether the held sample is overwritten;
- a label that coincides with the next start, which shows whether the error comes from the old sample and the new group is kept;
- non-start groups arriving while the holder is empty;
- uncorrectable labels and stray labels, checked through `drop_count`;
- reset asserted while a sample is pending.

// File: rtl/lbl_align_pkg.sv
package lbl_align_pkg;
  localparam int SYM_W      = 2;
  localparam int ERR_W      = 9;
  localparam int LEVEL_STEP = 85;

  function automatic logic [7:0] sym_to_level(input logic [SYM_W-1:0] sym);
    return 8'(LEVEL_STEP * int'(sym));
  endfunction
endpackage

// File: rtl/lba_cluster_ctr.sv
module lba_cluster_ctr #(
  parameter int CLUSTER_LEN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic grp_valid,
  output logic at_start
);
  localparam int PW = (CLUSTER_LEN > 2) ? $clog2(CLUSTER_LEN) : 1;

  logic [PW-1:0] pos;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= '0;
    end else if (grp_valid) begin
      if (pos == PW'(CLUSTER_LEN - 1)) pos <= '0;
      else                             pos <= pos + 1'b1;
    end
  end

  assign at_start = (pos == '0);
endmodule

// File: rtl/lba_sample_buf.sv
module lba_sample_buf #(
  parameter int DATA_W = 60
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              free,
  input  logic [DATA_W-1:0] din,
  output logic              pending,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] store;

  // data register has no reset so it maps to plain storage
  always_ff @(posedge clk) begin
    if (load) store <= din;
  end

  always_ff @(posedge clk) begin
    if (rst)       pending <= 1'b0;
    else if (load) pending <= 1'b1;
    else if (free) pending <= 1'b0;
  end

  assign dout = store;
endmodule

// File: rtl/lba_err_calc.sv
module lba_err_calc
  import lbl_align_pkg::*;
#(
  parameter int NEURONS = 5,
  parameter int ACC_W   = 12
) (
  input  logic [NEURONS*ACC_W-1:0] raw,
  input  logic [NEURONS*SYM_W-1:0] sym,
  output logic [NEURONS*ERR_W-1:0] err
);
  for (genvar k = 0; k < NEURONS; k++) begin : g_lane
    logic [ACC_W-1:0] r;
    logic [7:0]       lvl;
    logic             in_rng;

    assign r      = raw[k*ACC_W +: ACC_W];
    assign lvl    = sym_to_level(sym[k*SYM_W +: SYM_W]);
    // within 0..255 exactly when every bit above bit 7 is clear
    assign in_rng = (r[ACC_W-1:8] == '0);
    assign err[k*ERR_W +: ERR_W] = in_rng ? ({1'b0, r[7:0]} - {1'b0, lvl}) : '0;
  end
endmodule

// File: rtl/lbl_align_unit.sv
module lbl_align_unit
  import lbl_align_pkg::*;
#(
  parameter int NEURONS     = 5,
  parameter int ACC_W       = 12,
  parameter int CLUSTER_LEN = 8,
  parameter int CNT_W       = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     grp_valid,
  input  logic [NEURONS*ACC_W-1:0] grp_raw,
  input  logic                     lbl_valid,
  input  logic                     lbl_bad,
  input  logic [NEURONS*SYM_W-1:0] lbl_sym,
  output logic                     err_valid,
  output logic [NEURONS*ERR_W-1:0] err_vec,
  output logic [CNT_W-1:0]         drop_count
);
  localparam int RAW_W = NEURONS * ACC_W;

  logic             at_start, pending, take, capture;
  logic [RAW_W-1:0] held_raw;
  logic [NEURONS*ERR_W-1:0] err_next;

  lba_cluster_ctr #(.CLUSTER_LEN(CLUSTER_LEN)) u_ctr (
    .clk(clk), .rst(rst), .grp_valid(grp_valid), .at_start(at_start)
  );

  assign take    = pending & lbl_valid;
  assign capture = grp_valid & at_start & (~pending | take);

  lba_sample_buf #(.DATA_W(RAW_W)) u_buf (
    .clk(clk), .rst(rst), .load(capture), .free(take),
    .din(grp_raw), .pending(pending), .dout(held_raw)
  );

  lba_err_calc #(.NEURONS(NEURONS), .ACC_W(ACC_W)) u_calc (
    .raw(held_raw), .sym(lbl_sym), .err(err_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      err_valid  <= 1'b0;
      err_vec    <= '0;
      drop_count <= '0;
    end else begin
      err_valid <= take & ~lbl_bad;
      if (take & ~lbl_bad) err_vec <= err_next;
      if (take & lbl_bad)  drop_count <= drop_count + 1'b1;
    end
  end
endmodule

// File: rtl/lbl_align_unit_chk.sv
module lbl_align_unit_chk #(
  parameter int NEURONS = 5,
  parameter int ACC_W   = 12,
  parameter int CNT_W   = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     lbl_valid,
  input logic                     lbl_bad,
  input logic                     pending,
  input logic [NEURONS*ACC_W-1:0] held_raw,
  input logic                     err_valid,
  input logic [NEURONS*9-1:0]     err_vec,
  input logic [CNT_W-1:0]         drop_count
);
  a_r4_err_from_good_label: assert property (@(posedge clk) disable iff (rst)
    err_valid |-> $past(lbl_valid && !lbl_bad));

  a_r3_hold_while_waiting: assert property (@(posedge clk) disable iff (rst)
    (pending && !lbl_valid) |=> (pending && $stable(held_raw)));

  a_r5_drop_increments: assert property (@(posedge clk) disable iff (rst)
    (pending && lbl_valid && lbl_bad) |=> (!err_valid && drop_count == $past(drop_count) + 1'b1));

  a_r8_stray_label_ignored: assert property (@(posedge clk) disable iff (rst)
    (lbl_valid && !pending) |=> (!err_valid && $stable(drop_count)));

  for (genvar k = 0; k < NEURONS; k++) begin : g_lane_chk
    a_r7_lane_range: assert property (@(posedge clk) disable iff (rst)
      err_valid |-> (err_vec[k*9 +: 9] != 9'h100));
  end
endmodule

bind lbl_align_unit lbl_align_unit_chk #(.NEURONS(NEURONS), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .lbl_valid(lbl_valid), .lbl_bad(lbl_bad),
  .pending(pending), .held_raw(held_raw), .err_valid(err_valid),
  .err_vec(err_vec), .drop_count(drop_count)
);

// File: tb/lbl_align_unit_bench.sv
module lbl_align_unit_bench;
  localparam int N  = 5;
  localparam int AW = 12;
  localparam int CL = 8;
  localparam int CW = 16;
  localparam int NV = 5;

  localparam int VR [NV][N] = '{
    '{0, 85, 170, 255, 128},
    '{255, 0, 255, 0, 100},
    '{-5, 300, 256, -1, 50},
    '{-2048, 2047, 10, 200, 42},
    '{1, 2, 3, 4, 5}
  };
  localparam int VS [NV][N] = '{
    '{0, 1, 2, 3, 1},
    '{0, 3, 3, 0, 2},
    '{0, 1, 2, 3, 0},
    '{3, 3, 1, 2, 0},
    '{0, 0, 0, 0, 0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic grp_valid = 1'b0, lbl_valid = 1'b0, lbl_bad = 1'b0;
  logic [N*AW-1:0] grp_raw = '0;
  logic [N*2-1:0]  lbl_sym = '0;
  logic            err_valid;
  logic [N*9-1:0]  err_vec;
  logic [CW-1:0]   drop_count;

  int n_chk = 0, n_fail = 0, pos = 0;

  always #2 clk = ~clk;

  lbl_align_unit #(.NEURONS(N), .ACC_W(AW), .CLUSTER_LEN(CL), .CNT_W(CW)) u_lbl_align_unit (
    .clk(clk), .rst(rst), .grp_valid(grp_valid), .grp_raw(grp_raw),
    .lbl_valid(lbl_valid), .lbl_bad(lbl_bad), .lbl_sym(lbl_sym),
    .err_valid(err_valid), .err_vec(err_vec), .drop_count(drop_count)
  );

  function automatic logic [N*AW-1:0] raw_of(input int i);
    logic [N*AW-1:0] r;
    for (int k = 0; k < N; k++) r[k*AW +: AW] = AW'(VR[i][k]);
    return r;
  endfunction

  function automatic logic [N*2-1:0] sym_of(input int i);
    logic [N*2-1:0] s;
    for (int k = 0; k < N; k++) s[k*2 +: 2] = 2'(VS[i][k]);
    return s;
  endfunction

  // R6/R7 reference: target = 85*sym, error = raw - target, zero outside 0..255
  function automatic logic [N*9-1:0] exp_err(input int i);
    logic [N*9-1:0] e;
    for (int k = 0; k < N; k++) begin
      if (VR[i][k] < 0 || VR[i][k] > 255) e[k*9 +: 9] = '0;
      else e[k*9 +: 9] = 9'(VR[i][k] - 85 * VS[i][k]);
    end
    return e;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge; return once the posedge results are visible
  task automatic step(input logic gv, input logic [N*AW-1:0] raw,
                      input logic lv, input logic bad, input logic [N*2-1:0] sym);
    grp_valid = gv; grp_raw = raw; lbl_valid = lv; lbl_bad = bad; lbl_sym = sym;
    @(posedge clk); #1;
    if (gv) pos = (pos + 1) % CL;
    @(negedge clk);
    grp_valid = 0; lbl_valid = 0; lbl_bad = 0;
  endtask

  task automatic align();
    while (pos != 0) step(1, '1, 0, 0, '0);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R9 err_valid in reset", 64'(err_valid), 64'd0);
    check("R9 drop_count in reset", 64'(drop_count), 64'd0);
    rst = 0;

    // table walk: R4 R6 R7, also R1 (idle cycles do not advance)
    for (int i = 0; i < NV; i++) begin
      align();
      step(1, raw_of(i), 0, 0, '0);
      step(0, '0, 0, 0, '0);
      step(0, '0, 0, 0, '0);
      step(0, '0, 1, 0, sym_of(i));
      check("R4 err_valid on good label", 64'(err_valid), 64'd1);
      check("R7 err_vec", 64'(err_vec), 64'(exp_err(i)));
      step(0, '0, 0, 0, '0);
      check("R4 single-cycle strobe", 64'(err_valid), 64'd0);
    end

    // R3: start while pending is skipped
    align();
    step(1, raw_of(0), 0, 0, '0);
    for (int j = 1; j < CL; j++) step(1, raw_of(4), 0, 0, '0);
    step(1, raw_of(3), 0, 0, '0);
    step(0, '0, 1, 0, sym_of(0));
    check("R3 skipped start keeps old sample", 64'(err_vec), 64'(exp_err(0)));
    // pos now 1 and holder empty
    // R10: label together with next start
    align();
    step(1, raw_of(1), 0, 0, '0);
    for (int j = 1; j < CL; j++) step(1, raw_of(4), 0, 0, '0);
    step(1, raw_of(2), 1, 0, sym_of(1));
    check("R10 error from old sample", 64'(err_vec), 64'(exp_err(1)));
    step(0, '0, 1, 0, sym_of(2));
    check("R10 new sample captured", 64'(err_vec), 64'(exp_err(2)));
    check("R10 err_valid", 64'(err_valid), 64'd1);

    // R2: non-start groups are not captured (pos is 1, holder empty)
    for (int j = 1; j < CL; j++) step(1, raw_of(3), 0, 0, '0);
    step(0, '0, 1, 0, sym_of(3));
    check("R2 non-start not captured", 64'(err_valid), 64'd0);

    // R5: uncorrectable label dropped
    align();
    step(1, raw_of(0), 0, 0, '0);
    step(0, '0, 1, 1, sym_of(0));
    check("R5 no err_valid on bad label", 64'(err_valid), 64'd0);
    check("R5 drop_count", 64'(drop_count), 64'd1);
    // R8: stray labels ignored
    step(0, '0, 1, 1, '0);
    check("R8 stray bad label", 64'(drop_count), 64'd1);
    step(0, '0, 1, 0, sym_of(0));
    check("R8 stray good label", 64'(err_valid), 64'd0);

    // R9: reset while pending clears everything
    align();
    step(1, raw_of(0), 0, 0, '0);
    rst = 1;
    step(0, '0, 0, 0, '0);
    rst = 0;
    pos = 0;
    check("R9 drop_count cleared", 64'(drop_count), 64'd0);
    step(0, '0, 1, 0, sym_of(0));
    check("R9 holder emptied", 64'(err_valid), 64'd0);
    // R1: first group after reset is a start
    step(1, raw_of(4), 0, 0, '0);
    step(0, '0, 1, 0, sym_of(4));
    check("R1 start after reset", 64'(err_vec), 64'(exp_err(4)));

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule